// File: doc/BRIEF.md
# Decimated Bang-Bang Clock-Recovery Loop Filter

This block is the digital half of a clock-recovery loop for a half-rate receiver. Each clock it takes one 16-bit word of data samples and one 16-bit word of edge samples from the deserializer. It derives early/late phase votes from a decimated subset of bit positions and runs a proportional-integral filter once per word. The word rate is one sixteenth of the line rate.

The filter feeds two points of a fractional clock synthesizer. The integral path is added to the frequency control word and goes to the slow, high-order modulator. The proportional correction skips that modulator and goes straight to the input of the fast first-order stage, which keeps the loop latency low. A mode input selects transmit operation. In that mode the control word passes through unchanged, the proportional output is zero and the integrator is cleared.

Top module: `cdr_loop_filter`

## Requirements
- R1: While `rst_n` is low, both outputs are zero and the integrator is zero.
- R2: Votes are taken only at bit positions i = k*DECIM (i = 0 and 8 by default). Bit 0 is the earliest. `edge_i[i]` is the sample between `data_i[i]` and `data_i[i+1]`. A vote exists only when `data_i[i]` differs from `data_i[i+1]`. Transitions and edge values at all other positions have no effect.
- R3: A vote is early when `edge_i[i]` equals `data_i[i]` and late when it equals `data_i[i+1]`. The net vote of a word is the early count minus the late count, so it lies in -2..+2 by default.
- R4: In receive mode, `fast_adj_o` equals the net vote shifted left by `kp_shift_i` (a multiply by 2^kp_shift_i). It appears at the second rising edge after the samples are presented.
- R5: In receive mode, the integrator adds the net vote shifted left by `ki_shift_i` at the same edge where the proportional output updates.
- R6: In receive mode, `slow_word_o` equals `fcw_i` plus the sign-extended, newly updated integrator, modulo 2^FCW_W. It is registered at the same edge.
- R7: Transmit mode (`rx_mode_i` = 0) gives `fast_adj_o` = 0 and `slow_word_o` = `fcw_i` at the next edge and clears the integrator. After a return to receive mode, integration starts again from zero.
- R8: The integrator saturates at +2^(ACC_W-1)-1 and -2^(ACC_W-1) (32767 and -32768 by default) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode_i | input | 1 | 1 = receive (loop active), 0 = transmit |
| data_i | input | 16 | Deserialized data samples, bit 0 earliest |
| edge_i | input | 16 | Edge samples, bit i between data bits i and i+1 |
| fcw_i | input | 20 | Frequency control word from the frequency detector |
| kp_shift_i | input | 3 | Proportional gain as a left shift |
| ki_shift_i | input | 3 | Integral gain as a left shift |
| slow_word_o | output | 20 | Control word to the second-order modulator |
| fast_adj_o | output | 10 | Signed correction to the first-order stage input |

## Verification
Directed words with all-early, all-late, mixed and no-transition votes check the sign and the early-minus-late count. A word with heavy transition activity only at undecimated positions shows whether the decimator reads the wrong bits. Long runs of maximum-gain early and then late words drive the integrator into both rails, which separates saturation from wrap-around. Random words, gains, control words and mode toggles then test the pipeline alignment between the two injection paths and the clearing of the integrator in transmit mode.

// File: rtl/cdr_loop_pkg.sv
package cdr_loop_pkg;

    typedef enum logic {
        MODE_TX = 1'b0,
        MODE_RX = 1'b1
    } link_mode_e;

endpackage

// File: rtl/cdr_vote_decim.sv
module cdr_vote_decim #(
    parameter int WORD_W = 16,
    parameter int DECIM  = 8,
    parameter int VOTE_W = 3
) (
    input  logic [WORD_W-1:0]        data_i,
    input  logic [WORD_W-1:0]        edge_i,
    output logic signed [VOTE_W-1:0] vote_o
);
    localparam int NVOTE = WORD_W / DECIM;

    logic [NVOTE-1:0] early;
    logic [NVOTE-1:0] late;

    // Alexander detector at each decimated position
    for (genvar k = 0; k < NVOTE; k++) begin : g_pos
        localparam int P = k * DECIM;
        logic trans;
        assign trans    = data_i[P] ^ data_i[P+1];
        assign early[k] = trans & (edge_i[P] == data_i[P]);
        assign late[k]  = trans & (edge_i[P] == data_i[P+1]);
    end

    always_comb begin
        vote_o = '0;
        for (int k = 0; k < NVOTE; k++) begin
            vote_o = vote_o + VOTE_W'(early[k]) - VOTE_W'(late[k]);
        end
    end
endmodule

// File: rtl/cdr_gain_shift.sv
module cdr_gain_shift #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 10,
    parameter int SH_W  = 3
) (
    input  logic signed [IN_W-1:0]  val_i,
    input  logic [SH_W-1:0]         sh_i,
    output logic signed [OUT_W-1:0] val_o
);
    logic signed [OUT_W-1:0] ext;

    always_comb begin
        ext   = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
        val_o = ext <<< sh_i;
    end
endmodule

// File: rtl/cdr_sat_add.sv
module cdr_sat_add #(
    parameter int ACC_W  = 16,
    parameter int STEP_W = 10
) (
    input  logic signed [ACC_W-1:0]  acc_i,
    input  logic signed [STEP_W-1:0] step_i,
    output logic signed [ACC_W-1:0]  acc_o
);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0] sum;

    always_comb begin
        sum = {acc_i[ACC_W-1], acc_i}
            + {{(ACC_W+1-STEP_W){step_i[STEP_W-1]}}, step_i};
        if (sum[ACC_W] != sum[ACC_W-1]) begin
            acc_o = sum[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            acc_o = sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter #(
    parameter int WORD_W = 16,
    parameter int DECIM  = 8,
    parameter int SH_W   = 3,
    parameter int ACC_W  = 16,
    parameter int FCW_W  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_mode_i,
    input  logic [WORD_W-1:0]     data_i,
    input  logic [WORD_W-1:0]     edge_i,
    input  logic [FCW_W-1:0]      fcw_i,
    input  logic [SH_W-1:0]       kp_shift_i,
    input  logic [SH_W-1:0]       ki_shift_i,
    output logic [FCW_W-1:0]      slow_word_o,
    output logic signed [$clog2(WORD_W/DECIM+1)+2**SH_W-1:0] fast_adj_o
);
    import cdr_loop_pkg::*;

    localparam int NVOTE  = WORD_W / DECIM;
    localparam int VOTE_W = $clog2(NVOTE + 1) + 1;
    localparam int STEP_W = VOTE_W + 2**SH_W - 1;

    typedef struct packed {
        logic signed [VOTE_W-1:0] vote;
        logic signed [ACC_W-1:0]  integ;
        logic signed [STEP_W-1:0] prop;
        logic [FCW_W-1:0]         slow;
    } loop_state_t;

    loop_state_t st_d, st_q;

    logic signed [VOTE_W-1:0] vote_w;
    logic signed [STEP_W-1:0] prop_w;
    logic signed [STEP_W-1:0] istep_w;
    logic signed [ACC_W-1:0]  integ_sat_w;
    link_mode_e               mode;

    assign mode = link_mode_e'(rx_mode_i);

    cdr_vote_decim #(.WORD_W(WORD_W), .DECIM(DECIM), .VOTE_W(VOTE_W)) u_vote (
        .data_i (data_i),
        .edge_i (edge_i),
        .vote_o (vote_w)
    );

    cdr_gain_shift #(.IN_W(VOTE_W), .OUT_W(STEP_W), .SH_W(SH_W)) u_kp (
        .val_i (st_q.vote),
        .sh_i  (kp_shift_i),
        .val_o (prop_w)
    );

    cdr_gain_shift #(.IN_W(VOTE_W), .OUT_W(STEP_W), .SH_W(SH_W)) u_ki (
        .val_i (st_q.vote),
        .sh_i  (ki_shift_i),
        .val_o (istep_w)
    );

    cdr_sat_add #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_acc (
        .acc_i  (st_q.integ),
        .step_i (istep_w),
        .acc_o  (integ_sat_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vote = vote_w;
        if (mode == MODE_RX) begin
            st_d.integ = integ_sat_w;
            st_d.prop  = prop_w;
            st_d.slow  = fcw_i + {{(FCW_W-ACC_W){integ_sat_w[ACC_W-1]}}, integ_sat_w};
        end else begin
            st_d.integ = '0;
            st_d.prop  = '0;
            st_d.slow  = fcw_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slow_word_o = st_q.slow;
    assign fast_adj_o  = st_q.prop;
endmodule

// File: rtl/cdr_loop_checker.sv
module cdr_loop_checker #(
    parameter int WORD_W = 16,
    parameter int DECIM  = 8,
    parameter int SH_W   = 3,
    parameter int FCW_W  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_mode_i,
    input  logic [FCW_W-1:0]      fcw_i,
    input  logic [FCW_W-1:0]      slow_word_o,
    input  logic signed [$clog2(WORD_W/DECIM+1)+2**SH_W-1:0] fast_adj_o
);
    localparam int NVOTE   = WORD_W / DECIM;
    localparam int MAXSTEP = NVOTE * (2**(2**SH_W - 1));

    logic [FCW_W-1:0] fcw_last;
    logic [FCW_W-1:0] integ_prev;
    logic [FCW_W-1:0] integ_obs;
    logic [FCW_W-1:0] delta;
    logic             rx1, rx2;

    assign integ_obs = slow_word_o - fcw_last;
    assign delta     = integ_obs - integ_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcw_last   <= '0;
            integ_prev <= '0;
            rx1        <= 1'b0;
            rx2        <= 1'b0;
        end else begin
            fcw_last   <= fcw_i;
            integ_prev <= integ_obs;
            rx1        <= rx_mode_i;
            rx2        <= rx1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (slow_word_o == '0 && fast_adj_o == '0); // R1
        end
    end

    AST_TX_NO_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode_i |=> fast_adj_o == '0); // R7

    AST_TX_PASS_FCW: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode_i |=> slow_word_o == $past(fcw_i)); // R7

    AST_PROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fast_adj_o) <= MAXSTEP) && (int'(fast_adj_o) >= -MAXSTEP)); // R4

    AST_INTEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx1 && rx2) |-> ($signed(delta) <= MAXSTEP && $signed(delta) >= -MAXSTEP)); // R5
endmodule

bind cdr_loop_filter cdr_loop_checker #(
    .WORD_W (WORD_W),
    .DECIM  (DECIM),
    .SH_W   (SH_W),
    .FCW_W  (FCW_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_mode_i   (rx_mode_i),
    .fcw_i       (fcw_i),
    .slow_word_o (slow_word_o),
    .fast_adj_o  (fast_adj_o)
);

// File: tb/tb_cdr_loop_filter.sv
`timescale 1ns/1ps
module tb_cdr_loop_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_mode_i;
    logic [15:0] data_i, edge_i;
    logic [19:0] fcw_i;
    logic [2:0]  kp_shift_i, ki_shift_i;
    logic [19:0] slow_word_o;
    logic signed [9:0] fast_adj_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    int m_vote, m_integ, m_prop, m_slow;

    always #4 clk = ~clk;

    cdr_loop_filter dut (
        .clk(clk), .rst_n(rst_n), .rx_mode_i(rx_mode_i),
        .data_i(data_i), .edge_i(edge_i), .fcw_i(fcw_i),
        .kp_shift_i(kp_shift_i), .ki_shift_i(ki_shift_i),
        .slow_word_o(slow_word_o), .fast_adj_o(fast_adj_o)
    );

    function automatic int f_vote(logic [15:0] d, logic [15:0] e);
        int v = 0;
        for (int k = 0; k < 2; k++) begin
            int i = k * 8;
            if (d[i] != d[i+1]) v += (e[i] == d[i]) ? 1 : -1;
        end
        return v;
    endfunction

    function automatic int f_sat(int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_vote = 0; m_integ = 0; m_prop = 0; m_slow = 0;
        end else begin
            if (rx_mode_i) begin
                m_integ = f_sat(m_integ + m_vote * (1 << ki_shift_i));
                m_prop  = m_vote * (1 << kp_shift_i);
                m_slow  = (int'(fcw_i) + m_integ) & 32'hFFFFF;
            end else begin
                m_integ = 0; m_prop = 0; m_slow = int'(fcw_i);
            end
            m_vote = f_vote(data_i, edge_i);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        cycles++;
        chk({tag, " slow"}, int'(slow_word_o), m_slow);
        chk({tag, " fast"}, int'(fast_adj_o), m_prop);
    endtask

    task automatic set_in(logic rx, logic [15:0] d, logic [15:0] e,
                          logic [19:0] f, logic [2:0] kp, logic [2:0] ki);
        rx_mode_i = rx; data_i = d; edge_i = e; fcw_i = f;
        kp_shift_i = kp; ki_shift_i = ki;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        set_in(1'b1, 16'h0202, 16'h0000, 20'h12345, 3'd2, 3'd2);
        m_vote = 0; m_integ = 0; m_prop = 0; m_slow = 0;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero despite active inputs
        chk("R1 reset slow", int'(slow_word_o), 0);
        chk("R1 reset fast", int'(fast_adj_o), 0);
        rst_n = 1'b1;

        // R3 all-early: +2 with kp=0
        set_in(1'b1, 16'h0202, 16'h0000, 20'h01000, 3'd0, 3'd0);
        step("R3 early"); step("R3 early");
        chk("R3 early net", int'(fast_adj_o), 2);
        // R3 all-late: -2
        set_in(1'b1, 16'h0202, 16'h0101, 20'h01000, 3'd0, 3'd0);
        step("R3 late"); step("R3 late");
        chk("R3 late net", int'(fast_adj_o), -2);
        // R3 mixed: one late one early cancel
        set_in(1'b1, 16'h0202, 16'h0001, 20'h01000, 3'd0, 3'd0);
        step("R3 mixed"); step("R3 mixed");
        chk("R3 mixed net", int'(fast_adj_o), 0);
        // R2 transitions only at undecimated positions
        set_in(1'b1, 16'hF0F0, 16'hAAAA, 20'h01000, 3'd5, 3'd0);
        step("R2 ignored"); step("R2 ignored");
        chk("R2 ignored net", int'(fast_adj_o), 0);
        // R4 gain shift kp=3
        set_in(1'b1, 16'h0202, 16'h0000, 20'h01000, 3'd3, 3'd1);
        step("R4 gain"); step("R4 gain");
        chk("R4 prop gain", int'(fast_adj_o), 16);
        // R5/R6 integral via slow word
        step("R5 integ");
        chk("R6 slow sum", int'(slow_word_o), m_slow);

        // R7 transmit mode
        set_in(1'b0, 16'h0202, 16'h0000, 20'hABCDE, 3'd4, 3'd4);
        step("R7 tx"); step("R7 tx");
        chk("R7 tx fast", int'(fast_adj_o), 0);
        chk("R7 tx slow", int'(slow_word_o), 20'hABCDE);
        set_in(1'b1, 16'h0202, 16'h0000, 20'h00100, 3'd0, 3'd0);
        step("R7 reentry");
        chk("R7 reentry integ", int'(slow_word_o), 20'h00100 + 2);

        // R8 positive then negative saturation
        set_in(1'b1, 16'h0202, 16'h0000, 20'h40000, 3'd7, 3'd7);
        for (int i = 0; i < 200; i++) step("R8 sat hi");
        chk("R8 sat hi", int'(slow_word_o), 20'h40000 + 32767);
        set_in(1'b1, 16'h0202, 16'h0101, 20'h40000, 3'd7, 3'd7);
        for (int i = 0; i < 300; i++) step("R8 sat lo");
        chk("R8 sat lo", int'(slow_word_o), 20'h40000 - 32768);

        // R5 R6 R2 random mix
        for (int i = 0; i < 600; i++) begin
            set_in(($urandom_range(0, 9) != 0), 16'($urandom), 16'($urandom),
                   20'($urandom), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
            step("R5 R6 random");
        end

        done = 1;
        summary();
    end
endmodule